// File: doc/BRIEF.md
# Debounced Modem Status Monitor

This block watches two slow modem status inputs, carrier detect and clear to send, and drives one general-purpose output, request to send. Both inputs are resynchronised to the system clock. They are then sampled on a periodic tick that is divided down from the system clock, which is nominally 8 ms. No serial bit clock is involved, so monitoring continues while the line clocks are stopped. A new input level is accepted only after two successive tick samples both disagree with the current accepted level.

When reporting is enabled, each accepted change sets a sticky per-pin change flag and produces a single-cycle event pulse. The host clears the flags with a per-pin acknowledge. A read request returns a snapshot of the two accepted input levels and the output level. A write request sets the output pin.

Top module: `modem_status_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rts_o` is 1, `chg_flags_o` is 0, `event_o` is 0 and `rd_valid_o` is 0. The accepted levels of both inputs reset to 0.
- R2: Each monitored input passes through two synchroniser flops and is sampled only on a tick that occurs once every `TICK_CYCLES` system clocks. The event for an input that rises and then stays high appears between `TICK_CYCLES+4` and `2*TICK_CYCLES+3` falling clock edges after the change.
- R3: An accepted level changes when two successive tick samples both differ from it. The change takes effect at the second of those samples.
- R4: A tick sample that differs from the accepted level is discarded if the next sample equals the accepted level. A pulse shorter than `TICK_CYCLES` clocks therefore never changes the accepted level.
- R5: Reporting enabled means `report_en_i` is 1 in the cycle after an accepted change. In that case the change flag of that pin is set (bit 0 carrier detect, bit 1 clear to send), and `event_o` is 1 for exactly the same one cycle in which the flag becomes set.
- R6: With `report_en_i` at 0, an accepted change sets no flag and raises no event. The accepted level is still updated and shows in reads.
- R7: Asserting bit i of `ack_i` clears flag i on the next clock. A flag set and an acknowledge of the same pin in the same cycle leave the flag set.
- R8: `rd_req_i` gives `rd_valid_o` = 1 on the next cycle. `rd_data_o` then holds {request to send, clear to send, carrier detect} in bits 2, 1 and 0, taken as the values before that clock edge.
- R9: `wr_req_i` sets `rts_o` to `wr_level_i` on the next clock. A read in that same cycle returns the old output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_i | input | 1 | Carrier detect pin (asynchronous) |
| cts_i | input | 1 | Clear to send pin (asynchronous) |
| report_en_i | input | 1 | Change reporting enable |
| ack_i | input | 2 | Per-pin flag clear (bit 0 carrier detect, bit 1 clear to send) |
| rd_req_i | input | 1 | Pin snapshot request |
| wr_req_i | input | 1 | Output pin write request |
| wr_level_i | input | 1 | Level for the output pin write |
| rts_o | output | 1 | Request to send pin |
| chg_flags_o | output | 2 | Sticky change flags |
| event_o | output | 1 | One-cycle pulse per reported change |
| rd_valid_o | output | 1 | Snapshot valid |
| rd_data_o | output | 3 | Snapshot {rts, cts, cd} |

## Verification
The inputs are first held steady across many ticks, which separates correct two-sample confirmation from acceptance on a single sample or on three samples. Pulses shorter than one tick period are then applied and must leave the accepted level unchanged, which exposes a filter that reacts to one sample. A measured latency window separates a correctly divided tick from an off-by-one period. Long pseudo-random runs mix toggles, acknowledges, reads and writes with reporting switched on and off. They are compared each cycle against a behavioural model, which catches ordering faults such as an acknowledge overriding a same-cycle set, or a read returning the newly written output value.

// File: rtl/modem_mon_pkg.sv
package modem_mon_pkg;

    // Monitored input indices; flag and snapshot bit positions follow them
    localparam int unsigned PIN_CD   = 0;
    localparam int unsigned PIN_CTS  = 1;
    localparam int unsigned NUM_MON  = 2;
    localparam int unsigned SNAP_W   = NUM_MON + 1;

    // Per-input filter state
    typedef struct packed {
        logic [1:0] sync;       // two-flop synchroniser, [1] is the stable stage
        logic       first_diff; // previous tick sample disagreed with level
        logic       level;      // accepted level
        logic       changed;    // one-cycle pulse after acceptance
    } filt_state_t;

endpackage

// File: rtl/modem_tick_gen.sv
module modem_tick_gen #(
    parameter int unsigned TICK_CYCLES = 1600000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == LAST);

    generate
        if (TICK_CYCLES > 1) begin : g_tick_chk
            // R2
            tick_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("tick lasted more than one cycle");
        end
    endgenerate

endmodule

// File: rtl/modem_pin_filter.sv
module modem_pin_filter
    import modem_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic tick_i,
    output logic level_o,
    output logic changed_o
);

    filt_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.changed = 1'b0;
        st_d.sync    = {st_q.sync[0], pin_i};
        if (tick_i) begin
            if (st_q.sync[1] != st_q.level) begin
                if (st_q.first_diff) begin
                    st_d.level      = st_q.sync[1];
                    st_d.first_diff = 1'b0;
                    st_d.changed    = 1'b1;
                end else begin
                    st_d.first_diff = 1'b1;
                end
            end else begin
                st_d.first_diff = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o   = st_q.level;
    assign changed_o = st_q.changed;

    // R2
    level_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(level_o))
        else $error("accepted level moved without a tick");

    // R4
    level_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !st_q.first_diff) |=> $stable(level_o))
        else $error("accepted level moved on a single sample");

endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
    import modem_mon_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 1600000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cd_i,
    input  logic                 cts_i,
    input  logic                 report_en_i,
    input  logic [NUM_MON-1:0]   ack_i,
    input  logic                 rd_req_i,
    input  logic                 wr_req_i,
    input  logic                 wr_level_i,
    output logic                 rts_o,
    output logic [NUM_MON-1:0]   chg_flags_o,
    output logic                 event_o,
    output logic                 rd_valid_o,
    output logic [SNAP_W-1:0]    rd_data_o
);

    typedef struct packed {
        logic [NUM_MON-1:0] flags;
        logic               evt;
        logic               rd_valid;
        logic [SNAP_W-1:0]  rd_data;
        logic               rts;
    } mon_state_t;

    logic               tick;
    logic [NUM_MON-1:0] pins;
    logic [NUM_MON-1:0] levels;
    logic [NUM_MON-1:0] changed;
    logic [NUM_MON-1:0] report;

    mon_state_t st_d, st_q;

    assign pins[PIN_CD]  = cd_i;
    assign pins[PIN_CTS] = cts_i;

    modem_tick_gen #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    generate
        for (genvar i = 0; i < NUM_MON; i++) begin : g_filt
            modem_pin_filter u_filt (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_i     (pins[i]),
                .tick_i    (tick),
                .level_o   (levels[i]),
                .changed_o (changed[i])
            );
        end
    endgenerate

    assign report = changed & {NUM_MON{report_en_i}};

    always_comb begin
        st_d          = st_q;
        // set has priority over a same-cycle acknowledge
        st_d.flags    = (st_q.flags & ~ack_i) | report;
        st_d.evt      = |report;
        st_d.rd_valid = rd_req_i;
        if (rd_req_i) begin
            st_d.rd_data = {st_q.rts, levels};
        end
        if (wr_req_i) begin
            st_d.rts = wr_level_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rts <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_o       = st_q.rts;
    assign chg_flags_o = st_q.flags;
    assign event_o     = st_q.evt;
    assign rd_valid_o  = st_q.rd_valid;
    assign rd_data_o   = st_q.rd_data;

    // R5
    event_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (chg_flags_o != '0))
        else $error("event without a raised flag");

    // R6
    no_event_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !report_en_i |=> !event_o)
        else $error("event while reporting disabled");

    // R8
    read_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_valid_o)
        else $error("read request not answered");

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_i |=> (rts_o == $past(wr_level_i)))
        else $error("output write not applied");

endmodule

// File: tb/modem_status_monitor_bench.sv
module modem_status_monitor_bench;

    localparam int unsigned TICK = 6;
    localparam int unsigned WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cd = 1'b0, cts = 1'b0, report_en = 1'b1;
    logic [1:0] ack = 2'b00;
    logic       rd_req = 1'b0, wr_req = 1'b0, wr_level = 1'b0;
    logic       rts, evt, rd_valid;
    logic [1:0] flags;
    logic [2:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int evt_count = 0;

    always #2.5 clk = ~clk;

    modem_status_monitor #(.TICK_CYCLES(TICK)) u_modem_status_monitor (
        .clk(clk), .rst_n(rst_n), .cd_i(cd), .cts_i(cts),
        .report_en_i(report_en), .ack_i(ack), .rd_req_i(rd_req),
        .wr_req_i(wr_req), .wr_level_i(wr_level), .rts_o(rts),
        .chg_flags_o(flags), .event_o(evt), .rd_valid_o(rd_valid),
        .rd_data_o(rd_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int  m_cnt;
    bit  m_p1[2], m_p2[2], m_acc[2], m_pend[2], m_new[2];
    bit  m_flag[2];
    bit  m_evt, m_rv, m_rts;
    bit  [2:0] m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_evt = 0; m_rv = 0; m_rts = 1; m_rd = 0;
            for (int i = 0; i < 2; i++) begin
                m_p1[i] = 0; m_p2[i] = 0; m_acc[i] = 0; m_pend[i] = 0;
                m_new[i] = 0; m_flag[i] = 0;
            end
        end else begin
            bit sample_now;
            bit pin_now[2];
            sample_now = (m_cnt == TICK - 1);
            pin_now[0] = cd;
            pin_now[1] = cts;
            m_evt = 0;
            for (int i = 0; i < 2; i++) begin
                if (m_new[i] && report_en) begin
                    m_flag[i] = 1;
                    m_evt = 1;
                end else if (ack[i]) begin
                    m_flag[i] = 0;
                end
            end
            m_rv = rd_req;
            if (rd_req) m_rd = {m_rts, m_acc[1], m_acc[0]};
            if (wr_req) m_rts = wr_level;
            for (int i = 0; i < 2; i++) begin
                m_new[i] = 0;
                if (sample_now) begin
                    if (m_p2[i] != m_acc[i]) begin
                        if (m_pend[i]) begin
                            m_acc[i] = m_p2[i];
                            m_pend[i] = 0;
                            m_new[i] = 1;
                        end else begin
                            m_pend[i] = 1;
                        end
                    end else begin
                        m_pend[i] = 0;
                    end
                end
                m_p2[i] = m_p1[i];
                m_p1[i] = pin_now[i];
            end
            m_cnt = sample_now ? 0 : m_cnt + 1;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R9 rts", rts, m_rts);
            check("R5/R7 flag cd", flags[0], m_flag[0]);
            check("R5/R7 flag cts", flags[1], m_flag[1]);
            check("R5/R6 event", evt, m_evt);
            check("R8 rd_valid", rd_valid, m_rv);
            if (m_rv) check("R3/R8 rd_data", rd_data, m_rd);
            if (evt) evt_count++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(output logic [2:0] v);
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0; v = rd_data;
    endtask

    task automatic do_write(input logic lvl);
        @(negedge clk); wr_req = 1; wr_level = lvl;
        @(negedge clk); wr_req = 0;
    endtask

    initial begin
        logic [2:0] snap;
        int lat;

        // R1: reset state
        idle(3);
        check("R1 rts in reset", rts, 1);
        check("R1 flags in reset", flags, 0);
        check("R1 event in reset", evt, 0);
        check("R1 rd_valid in reset", rd_valid, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 rts after reset", rts, 1);
        check("R1 flags after reset", flags, 0);
        idle(2 * TICK);

        // R2/R3/R5: rising carrier detect, latency window
        cd = 1;
        lat = 0;
        for (int n = 1; n <= 4 * TICK; n++) begin
            @(negedge clk);
            if (evt && lat == 0) begin
                lat = n;
                check("R5 flag cd with event", flags, 2'b01);
            end
            if (lat != 0) break;
        end
        check("R2 latency lower bound", (lat >= TICK + 4) ? 1 : 0, 1);
        check("R2 latency upper bound", (lat <= 2 * TICK + 3) ? 1 : 0, 1);
        @(negedge clk);
        check("R5 event one cycle", evt, 0);
        check("R5 flag sticky", flags[0], 1);
        do_read(snap);
        check("R3 level cd accepted", snap, 3'b101);

        // R7: acknowledge
        @(negedge clk); ack = 2'b01;
        @(negedge clk); ack = 2'b00;
        check("R7 flag cleared", flags, 0);

        // R4: short glitches on clear to send
        for (int g = 0; g < 6; g++) begin
            cts = 1; idle(TICK / 2);
            cts = 0; idle(TICK + g);
        end
        idle(3 * TICK);
        do_read(snap);
        check("R4 glitch ignored level", snap[1], 0);
        check("R4 glitch no flag", flags[1], 0);

        // R6: reporting disabled
        report_en = 0;
        evt_count = 0;
        cts = 1;
        idle(4 * TICK);
        check("R6 no event", evt_count, 0);
        check("R6 no flag", flags, 0);
        do_read(snap);
        check("R6 level still updated", snap[1], 1);
        report_en = 1;

        // R7: set wins over a held acknowledge
        ack = 2'b01;
        cd = 0;
        lat = 0;
        for (int n = 0; n < 4 * TICK; n++) begin
            @(negedge clk);
            if (evt) begin
                lat = 1;
                check("R7 set beats ack", flags[0], 1);
                break;
            end
        end
        check("R7 change seen", lat, 1);
        @(negedge clk);
        check("R7 held ack clears next", flags[0], 0);
        ack = 2'b00;

        // R9: writes, and read in the same cycle as a write
        do_write(0);
        check("R9 rts low", rts, 0);
        @(negedge clk); wr_req = 1; wr_level = 1; rd_req = 1;
        @(negedge clk); wr_req = 0; rd_req = 0;
        check("R9 read sees old rts", rd_data[2], 0);
        check("R9 rts high", rts, 1);

        // mixed pseudo-random traffic against the model
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) cd = ~cd;
            if ($urandom_range(0, 11) == 0) cts = ~cts;
            ack       = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            rd_req    = ($urandom_range(0, 3) == 0);
            wr_req    = ($urandom_range(0, 9) == 0);
            wr_level  = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 199) == 0) report_en = ~report_en;
        end
        rd_req = 0; wr_req = 0; ack = 0;
        idle(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule